// File: doc/BRIEF.md
# SD Four-Bit Data Block Engine

This block moves one 512-byte block at a time across a four-line SD card data bus. A command engine starts it with a one-cycle pulse and the six-bit index of the command it has just issued. Index 24 begins a single-block write and index 17 begins a single-block read. Any other index leaves the block idle.

For a write, bytes come from a show-ahead transmit FIFO and go out as nibbles. Each transfer carries a start nibble, the data, a CRC16 computed separately on each line, and an end nibble. The card then answers on line 0 with a short status token. The block hands that token to software as one ordinary byte in the receive FIFO, where the pattern 0x29 means the card accepted the data. The block then waits for the card to stop signalling busy.

For a read, the block waits for the card's start nibble. It assembles the following nibbles into 512 bytes, pushes them into the receive FIFO in arrival order, and checks each line's CRC16 and the end nibble.

Top module: `sd_block_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `dat_oe`, `done`, `crc_err`, `tx_pop` and `rx_push` are all low.
- R2: When `start` is seen in idle, `cmd_idx` = 24 starts a write and `cmd_idx` = 17 starts a read, and `busy` is high in the following cycle. Any other index leaves the block idle with the bus undriven.
- R3: A write drives the bus for exactly 1042 consecutive cycles with `dat_oe` high. These are one start nibble 0x0, then 1024 data nibbles (the high nibble of each byte first, with bit i of the nibble on line i), then 16 CRC nibbles, then one end nibble 0xF.
- R4: A write pops the transmit FIFO exactly 512 times, once per byte, in the cycle that drives the byte's low nibble.
- R5: Each line carries its own CRC16: polynomial 0x1021, initial value 0, computed over the 1024 data bits of that line and sent most significant bit first.
- R6: After the end nibble, the block waits for line 0 to go low. It captures that start bit and the 7 samples after it, most significant bit first, and pushes them as one byte into the receive FIFO (0x29 is the accepted pattern).
- R7: After the token, `busy` stays high while line 0 is low. The first high sample on line 0 ends the write with a one-cycle `done` pulse.
- R8: A read waits for all four lines low. It then takes 1024 nibbles and pushes 512 bytes, each formed as {first nibble, second nibble}, in arrival order. It then takes 16 CRC nibbles and one end nibble, and pulses `done` in the cycle after the end nibble.
- R9: At the end of a read, `crc_err` is set if any line's CRC16 disagrees or the end nibble is not 0xF. All 512 bytes are still delivered. `crc_err` holds its value in idle and clears when the next command is accepted.
- R10: `start` has no effect while `busy` is high.
- R11: `dat_oe` is never high during a read or in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus nibble per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle command-issued pulse |
| cmd_idx | input | 6 | Index of the issued command |
| tx_data | input | 8 | Head byte of the show-ahead transmit FIFO |
| tx_pop | output | 1 | Consume the head byte of the transmit FIFO |
| rx_push | output | 1 | Write `rx_data` into the receive FIFO |
| rx_data | output | 8 | Byte for the receive FIFO |
| dat_in | input | 4 | Sampled SD data lines |
| dat_out | output | 4 | Value driven onto the SD data lines |
| dat_oe | output | 1 | Output enable for the SD data lines |
| busy | output | 1 | A block transfer is in progress |
| done | output | 1 | One-cycle pulse when a transfer finishes |
| crc_err | output | 1 | Last read failed its CRC or end-nibble check |

## Verification
The bench models the card. It records every driven nibble and recomputes the four line CRCs, so a design that swapped nibble order, mixed lines, or added or lost one cycle of the frame shows up as a length or content mismatch.

On writes it drives tokens with and without a busy period. A design that reported done on the token itself, or pushed the wrong bit window, gives a wrong byte or an early `done` pulse.

On reads it corrupts one CRC bit in one run and the end nibble in another. It then expects the full 512 bytes plus a raised error flag, and it expects the flag to persist through idle and clear at the next command.

It also pulses `start` in the middle of a read and issues unrelated indices. A design that reacted would drive the bus or pop bytes.

// File: rtl/sdblk_pkg.sv
package sdblk_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WSTART,
    ST_WDATA,
    ST_WCRC,
    ST_WEND,
    ST_WTOKW,
    ST_WTOK,
    ST_WBUSY,
    ST_RWAIT,
    ST_RDATA,
    ST_RCRC,
    ST_REND
  } sdblk_state_e;

  localparam logic [15:0] SDBLK_CRC_POLY = 16'h1021;

endpackage

// File: rtl/sdblk_crc_lane.sv
module sdblk_crc_lane #(
  parameter int                CRC_W = 16,
  parameter logic [CRC_W-1:0]  POLY  = 16'h1021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;
  logic             fb;

  always_comb begin
    fb    = crc_q[CRC_W-1] ^ bit_i;
    crc_d = crc_q;
    if (clr) begin
      crc_d = '0;
    end else if (en) begin
      crc_d = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc_o = crc_q;

  AST_CRC_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !en) |=> $stable(crc_o)); // R5

endmodule

// File: rtl/sdblk_counter.sv
module sdblk_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/sd_block_engine.sv
module sd_block_engine
  import sdblk_pkg::*;
#(
  parameter int BLOCK_BYTES = 512,
  parameter int BYTE_W      = 8,
  parameter int CRC_W       = 16,
  parameter int IDX_W       = 6,
  parameter int WR_INDEX    = 24,
  parameter int RD_INDEX    = 17,
  parameter int TOK_BITS    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [BYTE_W-1:0] rx_data,
  input  logic [3:0]        dat_in,
  output logic [3:0]        dat_out,
  output logic              dat_oe,
  output logic              busy,
  output logic              done,
  output logic              crc_err
);

  localparam int LANES   = BYTE_W / 2;
  localparam int NIBBLES = BLOCK_BYTES * 2;
  localparam int CNT_W   = $clog2(NIBBLES);
  localparam logic [CNT_W-1:0] LAST_NIB = CNT_W'(NIBBLES - 1);
  localparam logic [CNT_W-1:0] LAST_CRC = CNT_W'(CRC_W - 1);
  localparam logic [CNT_W-1:0] LAST_TOK = CNT_W'(TOK_BITS - 2);

  sdblk_state_e st_q, st_d;
  logic [CNT_W-1:0]    cnt;
  logic                cnt_inc;
  logic [LANES-1:0]    hi_q;
  logic [TOK_BITS-2:0] tok_q;
  logic                err_q, err_d, err_en;
  logic                done_q;
  logic                accept;
  logic                writing, lane_en;
  logic [LANES-1:0]    crc_msb, crc_nz, lane_bit;
  logic [CRC_W-1:0]    lane_crc [LANES];

  // next-state logic
  always_comb begin
    st_d   = st_q;
    accept = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start && cmd_idx == IDX_W'(WR_INDEX)) begin
          st_d = ST_WSTART; accept = 1'b1;
        end else if (start && cmd_idx == IDX_W'(RD_INDEX)) begin
          st_d = ST_RWAIT;  accept = 1'b1;
        end
      end
      ST_WSTART: st_d = ST_WDATA;
      ST_WDATA:  if (cnt == LAST_NIB) st_d = ST_WCRC;
      ST_WCRC:   if (cnt == LAST_CRC) st_d = ST_WEND;
      ST_WEND:   st_d = ST_WTOKW;
      ST_WTOKW:  if (!dat_in[0]) st_d = ST_WTOK;
      ST_WTOK:   if (cnt == LAST_TOK) st_d = ST_WBUSY;
      ST_WBUSY:  if (dat_in[0]) st_d = ST_IDLE;
      ST_RWAIT:  if (dat_in == '0) st_d = ST_RDATA;
      ST_RDATA:  if (cnt == LAST_NIB) st_d = ST_RCRC;
      ST_RCRC:   if (cnt == LAST_CRC) st_d = ST_REND;
      ST_REND:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign cnt_inc = (st_q == ST_WDATA) || (st_q == ST_WCRC) || (st_q == ST_WTOK) ||
                   (st_q == ST_RDATA) || (st_q == ST_RCRC);

  sdblk_counter #(.W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_d != st_q),
    .inc   (cnt_inc),
    .cnt_o (cnt)
  );

  // per-line CRC
  assign writing = (st_q == ST_WDATA) || (st_q == ST_WCRC);
  assign lane_en = writing || (st_q == ST_RDATA) || (st_q == ST_RCRC);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_bit[i] = writing ? dat_out[i] : dat_in[i];
    sdblk_crc_lane #(.CRC_W(CRC_W), .POLY(SDBLK_CRC_POLY)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_q == ST_IDLE),
      .en    (lane_en),
      .bit_i (lane_bit[i]),
      .crc_o (lane_crc[i])
    );
    assign crc_msb[i] = lane_crc[i][CRC_W-1];
    assign crc_nz[i]  = |lane_crc[i];
  end

  // bus drive
  always_comb begin
    dat_out = '0;
    unique case (st_q)
      ST_WDATA: dat_out = cnt[0] ? tx_data[LANES-1:0] : tx_data[BYTE_W-1:LANES];
      ST_WCRC:  dat_out = crc_msb;
      ST_WEND:  dat_out = '1;
      default:  dat_out = '0;
    endcase
  end

  assign dat_oe = (st_q == ST_WSTART) || writing || (st_q == ST_WEND);
  assign tx_pop = (st_q == ST_WDATA) && cnt[0];

  // receive side registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      tok_q <= '0;
    end else begin
      if (st_q == ST_RDATA && !cnt[0]) hi_q <= dat_in;
      if (st_q == ST_WTOKW || st_q == ST_WTOK) tok_q <= {tok_q[TOK_BITS-3:0], dat_in[0]};
    end
  end

  assign rx_push = ((st_q == ST_RDATA) && cnt[0]) || ((st_q == ST_WTOK) && cnt == LAST_TOK);
  assign rx_data = (st_q == ST_WTOK) ? {tok_q, dat_in[0]} : {hi_q, dat_in};

  // status
  assign err_en = accept || (st_q == ST_REND);
  assign err_d  = (st_q == ST_REND) ? ((|crc_nz) || (dat_in != '1)) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (err_en) err_q <= err_d;
      done_q <= ((st_q == ST_WBUSY) && dat_in[0]) || (st_q == ST_REND);
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign crc_err = err_q;

  AST_OE_ONLY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dat_oe |-> busy); // R11
  AST_START_NIBBLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dat_oe) |-> (dat_out == '0)); // R3
  AST_POP_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> dat_oe); // R4
  AST_NO_PUSH_WHILE_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !dat_oe); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_ERR_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(crc_err)); // R9
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && st_q == ST_RDATA) |=> !dat_oe); // R10

endmodule

// File: tb/sim_sd_block_engine.sv
`timescale 1ns/100ps
module sim_sd_block_engine;

  logic       clk = 1'b0;
  logic       rst_n, start;
  logic [5:0] cmd_idx;
  logic [7:0] tx_data;
  logic       tx_pop, rx_push;
  logic [7:0] rx_data;
  logic [3:0] dat_in, dat_out;
  logic       dat_oe, busy, done, crc_err;

  always #2.5 clk = ~clk;

  sd_block_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_idx(cmd_idx),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe),
    .busy(busy), .done(done), .crc_err(crc_err)
  );

  // stimulus table: op(1=write) | seed | token | busy cycles | crc bad | end bad | mid-read start
  localparam logic [27:0] VECS [0:6] = '{
    {1'b1, 8'h11, 8'h29, 8'd4, 3'b000},
    {1'b0, 8'h22, 8'h00, 8'd0, 3'b001},
    {1'b0, 8'h33, 8'h00, 8'd0, 3'b100},
    {1'b1, 8'h44, 8'h6B, 8'd0, 3'b000},
    {1'b0, 8'h55, 8'h00, 8'd0, 3'b010},
    {1'b0, 8'h66, 8'h00, 8'd0, 3'b000},
    {1'b1, 8'h77, 8'h29, 8'd9, 3'b000}
  };

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] txmem  [0:511];
  logic [3:0] exp_nib [0:1041];
  logic [7:0] rx_log [0:1023];
  logic [3:0] wlog   [0:2047];
  int pops = 0, tx_base = 0, rx_total = 0, oe_total = 0, done_total = 0;

  assign tx_data = txmem[(pops - tx_base) & 511];

  always @(posedge clk) begin
    if (tx_pop) pops <= pops + 1;
    if (rx_push) begin
      rx_log[rx_total & 1023] <= rx_data;
      rx_total <= rx_total + 1;
    end
  end

  always @(negedge clk) begin
    if (dat_oe) begin
      wlog[oe_total & 2047] = dat_out;
      oe_total = oe_total + 1;
    end
    if (done) done_total = done_total + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  function automatic logic [7:0] pat(input logic [7:0] s, input int j);
    int v;
    v = s * 7 + j * 13 + (j >> 3) + ((j * j) >> 5);
    return v[7:0];
  endfunction

  function automatic logic [15:0] cstep(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? 16'h1021 : 16'h0000);
  endfunction

  task automatic build(input logic [7:0] seed);
    logic [15:0] c [4];
    for (int i = 0; i < 4; i++) c[i] = '0;
    exp_nib[0] = 4'h0;
    for (int j = 0; j < 512; j++) begin
      logic [7:0] b;
      b = pat(seed, j);
      txmem[j] = b;
      exp_nib[1 + 2*j] = b[7:4];
      exp_nib[2 + 2*j] = b[3:0];
    end
    for (int k = 1; k <= 1024; k++)
      for (int i = 0; i < 4; i++) c[i] = cstep(c[i], exp_nib[k][i]);
    for (int k = 0; k < 16; k++)
      for (int i = 0; i < 4; i++) exp_nib[1025 + k][i] = c[i][15 - k];
    exp_nib[1041] = 4'hF;
  endtask

  task automatic run_write(input logic [7:0] seed, input logic [7:0] tok, input int blen);
    int ob, rb, db, pb, guard, bad_d, bad_c;
    build(seed);
    step();
    tx_base = pops; pb = pops; ob = oe_total; rb = rx_total; db = done_total;
    cmd_idx = 6'd24; start = 1'b1;
    step();
    start = 1'b0;
    chk(busy == 1'b1, "R2 write accepted busy", busy, 1);
    chk(crc_err == 1'b0, "R9 error cleared on accept", crc_err, 0);
    guard = 0;
    while (!((oe_total - ob) > 0 && !dat_oe) && guard < 3000) begin step(); guard++; end
    chk(oe_total - ob == 1042, "R3 driven frame length", oe_total - ob, 1042);
    chk(wlog[ob & 2047] == 4'h0, "R3 start nibble", wlog[ob & 2047], 0);
    bad_d = 0; bad_c = 0;
    for (int k = 1; k <= 1024; k++) if (wlog[(ob + k) & 2047] != exp_nib[k]) bad_d++;
    for (int k = 1025; k <= 1040; k++) if (wlog[(ob + k) & 2047] != exp_nib[k]) bad_c++;
    chk(bad_d == 0, "R3 data nibbles", bad_d, 0);
    chk(bad_c == 0, "R5 per-line CRC nibbles", bad_c, 0);
    chk(wlog[(ob + 1041) & 2047] == 4'hF, "R3 end nibble", wlog[(ob + 1041) & 2047], 15);
    chk(pops - pb == 512, "R4 pop count", pops - pb, 512);
    dat_in = 4'hF; step(); step();
    for (int b = 7; b >= 0; b--) begin dat_in = {3'b111, tok[b]}; step(); end
    for (int n = 0; n < blen; n++) begin dat_in = 4'hE; step(); end
    chk(done_total - db == 0, "R7 no done while card busy", done_total - db, 0);
    chk(busy == 1'b1, "R7 busy while card busy", busy, 1);
    dat_in = 4'hF; step(); step();
    chk(done_total - db == 1, "R7 one done after release", done_total - db, 1);
    chk(busy == 1'b0, "R7 idle after release", busy, 0);
    chk(rx_total - rb == 1, "R6 one token byte", rx_total - rb, 1);
    chk(rx_log[rb & 1023] == tok, "R6 token byte value", rx_log[rb & 1023], tok);
  endtask

  task automatic run_read(input logic [7:0] seed, input bit cbad, input bit ebad, input bit inj);
    int ob, rb, db, pb, bad;
    build(seed);
    step();
    ob = oe_total; rb = rx_total; db = done_total; pb = pops;
    cmd_idx = 6'd17; start = 1'b1;
    step();
    start = 1'b0;
    chk(busy == 1'b1, "R2 read accepted busy", busy, 1);
    chk(crc_err == 1'b0, "R9 error cleared on accept", crc_err, 0);
    dat_in = 4'hF; step(); step(); step();
    for (int k = 0; k < 1042; k++) begin
      logic [3:0] n;
      n = exp_nib[k];
      if (cbad && k == 1030) n = n ^ 4'b0100;
      if (ebad && k == 1041) n = 4'hB;
      dat_in = n;
      if (inj && k == 100) begin cmd_idx = 6'd24; start = 1'b1; end
      else start = 1'b0;
      step();
    end
    dat_in = 4'hF; start = 1'b0;
    chk(done_total - db == 1, "R8 done after end nibble", done_total - db, 1);
    chk(busy == 1'b0, "R8 idle after read", busy, 0);
    chk(rx_total - rb == 512, "R8 byte count", rx_total - rb, 512);
    bad = 0;
    for (int j = 0; j < 512; j++) if (rx_log[(rb + j) & 1023] != txmem[j]) bad++;
    chk(bad == 0, "R8 byte order and value", bad, 0);
    chk(crc_err == (cbad | ebad), "R9 read check flag", crc_err, cbad | ebad);
    chk(oe_total - ob == 0, "R11 bus undriven in read", oe_total - ob, 0);
    if (inj) chk(pops - pb == 0, "R10 start while busy ignored", pops - pb, 0);
    step(); step(); step();
    chk(crc_err == (cbad | ebad), "R9 flag held in idle", crc_err, cbad | ebad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R7 watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; cmd_idx = '0; dat_in = 4'hF;
    for (int j = 0; j < 512; j++) txmem[j] = '0;
    repeat (5) step();
    chk({busy, dat_oe, done, crc_err, tx_pop, rx_push} == 6'b0, "R1 outputs in reset",
        {busy, dat_oe, done, crc_err, tx_pop, rx_push}, 0);
    rst_n = 1'b1;
    step();
    chk({busy, dat_oe, done, crc_err, tx_pop, rx_push} == 6'b0, "R1 outputs after reset",
        {busy, dat_oe, done, crc_err, tx_pop, rx_push}, 0);

    for (int v = 0; v < 7; v++) begin
      logic [27:0] e;
      e = VECS[v];
      if (e[27]) run_write(e[26:19], e[18:11], int'(e[10:3]));
      else       run_read(e[26:19], e[2], e[1], e[0]);
    end

    // unrelated command indices leave the block idle
    begin
      int ob, pb;
      ob = oe_total; pb = pops;
      cmd_idx = 6'd18; start = 1'b1; step();
      cmd_idx = 6'd25; step();
      start = 1'b0; step(); step();
      chk(busy == 1'b0, "R2 other index ignored", busy, 0);
      chk(oe_total - ob == 0 && pops - pb == 0, "R2 no bus activity on other index",
          oe_total - ob, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule